// File: doc/BRIEF.md
# Modulo-4 Dual-Input Ones Counter

This block watches two single-bit data lines and keeps, modulo four, a running total of how many of their bits have been 1 since the last reset. On each rising clock edge it adds to the total the number of lines that are high: zero, one or two. Its one output goes high whenever the total is a whole multiple of four.

The residue is kept in a two-bit register that uses reflected Gray order. The four residue values map to codes as follows: residue 0 is `00`, residue 1 is `01`, residue 2 is `11` and residue 3 is `10`. Because the output is decoded from that register alone, it is a Moore output. It changes only at a clock edge, never in response to an input between edges. Reset is synchronous and active high.

A typical use is a parity-like tally of events on a pair of strobes, where only "divisible by four" has to be known downstream.

Top module: `pair_ones_residue`

## Requirements
- R1: With `rst` high at a rising edge, the residue returns to 0 regardless of `x_in`/`y_in`, so `z_out` is 1 after that edge.
- R2: `z_out` is 1 exactly when the stored residue is 0, using the code map residue 0=`00`, 1=`01`, 2=`11`, 3=`10`. It is 0 for residues 1, 2 and 3.
- R3: An edge with `x_in`=0 and `y_in`=0 leaves the residue unchanged.
- R4: An edge with exactly one of `x_in`, `y_in` high advances the residue by one, with 3 wrapping to 0. Each such step flips exactly one bit of the stored code.
- R5: An edge with both inputs high advances the residue by two, modulo four. Each such step flips both bits of the stored code.
- R6: `z_out` depends only on the registered residue. Changing `x_in` or `y_in` between edges does not change `z_out` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to residue 0 |
| x_in | input | 1 | First data line; counts one when high |
| y_in | input | 1 | Second data line; counts one when high |
| z_out | output | 1 | High when the ones total is a multiple of four |

## Verification
The counter is driven with quiet cycles, single-line pulses on each line separately, and simultaneous pulses on both lines.

- Quiet cycles separate holding from drifting.
- Single-line pulses confirm that the two lines count alike.
- Simultaneous pulses separate a double step from a single step and exercise the wrap from residue 3 through 0 to 1.

A long mixed sequence is compared against a free-running modulo-4 sum. Toggling the inputs mid-cycle shows that the output does not react between edges. A reset issued while both lines are high shows that reset takes priority over counting.

// File: rtl/ones_res_pkg.sv
package ones_res_pkg;

    localparam int RES_W = 2;

    typedef logic [RES_W-1:0] res_t;

    typedef struct packed {
        res_t code;
    } ctr_state_t;

    function automatic res_t bin_to_gray(input res_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic res_t gray_to_bin(input res_t g);
        res_t b;
        b[RES_W-1] = g[RES_W-1];
        for (int i = RES_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/line_weight.sv
module line_weight #(
    parameter int LINES = 2,
    localparam int WW = $clog2(LINES + 1)
) (
    input  logic [LINES-1:0] lines,
    output logic [WW-1:0]    weight
);

    always_comb begin
        weight = '0;
        for (int i = 0; i < LINES; i++) begin
            weight = weight + WW'(lines[i]);
        end
    end

endmodule

// File: rtl/gray_advance.sv
module gray_advance
    import ones_res_pkg::*;
#(
    parameter int WW = 2
) (
    input  res_t          code_cur,
    input  logic [WW-1:0] step,
    output res_t          code_nxt
);

    res_t bin_cur;
    res_t bin_nxt;

    always_comb begin
        bin_cur  = gray_to_bin(code_cur);
        bin_nxt  = bin_cur + RES_W'(step);
        code_nxt = bin_to_gray(bin_nxt);
    end

endmodule

// File: rtl/pair_ones_residue.sv
module pair_ones_residue
    import ones_res_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    input  logic y_in,
    output logic z_out
);

    localparam int LINES = 2;
    localparam int WW    = $clog2(LINES + 1);

    ctr_state_t    state_d;
    ctr_state_t    state_q;
    logic [WW-1:0] weight;
    res_t          code_adv;

    line_weight #(.LINES(LINES)) u_weight (
        .lines  ({y_in, x_in}),
        .weight (weight)
    );

    gray_advance #(.WW(WW)) u_adv (
        .code_cur (state_q.code),
        .step     (weight),
        .code_nxt (code_adv)
    );

    // Next-state selection: reset has priority over counting.
    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.code = bin_to_gray('0);
        end else begin
            state_d.code = code_adv;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // Moore output: decoded from the register only.
    assign z_out = (state_q.code == bin_to_gray('0));

endmodule

// File: rtl/pair_ones_residue_checker.sv
module pair_ones_residue_checker
    import ones_res_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x_in,
    input logic       y_in,
    input logic       z_out,
    input ctr_state_t state_q
);

    // R1: the first cycle out of reset shows residue 0 and a high output.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (z_out && state_q.code == 2'b00));

    // R3: quiet inputs hold the stored code.
    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!x_in && !y_in) |=> $stable(state_q.code));

    // R4: a single step changes exactly one code bit.
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        (x_in ^ y_in) |=> ($countones(state_q.code ^ $past(state_q.code)) == 1));

    // R5: a double step changes both code bits.
    assert_double_step_R5: assert property (@(posedge clk) disable iff (rst)
        (x_in && y_in) |=> ($countones(state_q.code ^ $past(state_q.code)) == 2));

    // R2: residue 0 with quiet inputs keeps the output high.
    assert_zero_residue_R2: assert property (@(posedge clk) disable iff (rst)
        (z_out && !x_in && !y_in) |=> z_out);

    // R6: the output never moves unless the register moves.
    assert_output_registered_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(z_out) |-> !$stable(state_q.code));

endmodule

bind pair_ones_residue pair_ones_residue_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .x_in    (x_in),
    .y_in    (y_in),
    .z_out   (z_out),
    .state_q (state_q)
);

// File: tb/pair_ones_residue_test.sv
`timescale 1ns/1ps
module pair_ones_residue_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic y_in = 1'b0;
    logic z_out;

    int checks = 0;
    int errors = 0;
    int model_acc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pair_ones_residue uut (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .y_in  (y_in),
        .z_out (z_out)
    );

    task automatic check_z(input string req, input logic exp);
        checks++;
        if (z_out !== exp) begin
            errors++;
            $display("FAIL %s: z_out=%b expected=%b (acc=%0d)", req, z_out, exp, model_acc);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass,
    // then sample at the next falling edge.
    task automatic step(input logic xv, input logic yv, input string req);
        x_in = xv;
        y_in = yv;
        @(posedge clk);
        if (rst) model_acc = 0;
        else model_acc = (model_acc + int'(xv) + int'(yv)) % 4;
        @(negedge clk);
        check_z(req, model_acc == 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step(1'b1, 1'b1, "R1");
        rst = 1'b0;
        x_in = 1'b0;
        y_in = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check_z("R1", 1'b1);
    endtask

    task automatic t_hold();
        step(1'b1, 1'b0, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R3");
        check_z("R3", 1'b0);
    endtask

    task automatic t_single();
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R4");
        check_z("R4", 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R4");
        check_z("R4", 1'b1);
    endtask

    task automatic t_double();
        do_reset();
        step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b1, "R5");
        check_z("R5", 1'b1);
        step(1'b1, 1'b0, "R4");
        step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b1, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b1, "R2");
    endtask

    task automatic t_mixed();
        do_reset();
        for (int i = 0; i < 60; i++) begin
            step(1'((i * 7 + 3) % 5 < 2), 1'((i * 3 + 1) % 4 == 0), "R2");
        end
    endtask

    task automatic t_registered();
        do_reset();
        step(1'b1, 1'b0, "R4");
        x_in = 1'b1;
        y_in = 1'b1;
        #1;
        check_z("R6", 1'b0);
        x_in = 1'b0;
        y_in = 1'b1;
        #0.5;
        check_z("R6", 1'b0);
        step(1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, "R6");
        x_in = 1'b1;
        #1;
        check_z("R6", 1'b0);
    endtask

    task automatic t_reset_priority();
        step(1'b1, 1'b0, "R4");
        do_reset();
        check_z("R1", 1'b1);
        step(1'b0, 1'b0, "R3");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_hold();
        t_single();
        t_double();
        t_mixed();
        t_registered();
        t_reset_priority();
        finish_run();
    end

endmodule